// File: doc/BRIEF.md
# Per-Virtual-Link Queue Selector

This block sits at the entry of a queue manager. The classifier hands it one descriptor at a time. Each descriptor carries a 16-bit flag word, a virtual link number, a queue ID, a 20-bit packet pointer and an 11-bit total length. The block reads the flags and decides what happens to the packet. It either becomes an enqueue request on a flat queue index, goes to a special-handling output, or is discarded. When a discarded packet is the last copy of its payload, the block hands the payload pointer to the buffer manager for release.

The queue space is split into sets. Each of the `NUM_LINKS` virtual links owns one set of `QSET_SIZE` queues (256 or 512). One further set, numbered `NUM_LINKS`, serves the plugin subsystem. The first 64 queues of every set carry datagram traffic and the rest are reserved queues. The flat index is the set number placed above the in-set queue offset.

All three outputs are registered, one clock after acceptance. Each output keeps its contents until its consumer takes them. The input handshake stalls only while an output that is still loaded is not being drained in the same cycle.

Top module: `qsel_front`

## Requirements
- R1: For a non-dropped packet with no special flags, one clock after acceptance `enq_valid` rises. `enq_index` = link*QSET_SIZE + (qid mod QSET_SIZE), and pointer and length are passed unchanged.
- R2: With the datagram flag (flag bit 8) set, the in-set offset is qid mod 64 instead of qid mod QSET_SIZE.
- R3: With the plugin flag (flag bit 10) set, the set number is NUM_LINKS (8 by default) whatever the link input holds.
- R4: With the drop flag (flag bit 0) set, the packet reaches neither the enqueue output nor the special-handling output, even when other flags are also set.
- R5: A dropped packet whose final-copy flag (flag bit 9) is set puts its pointer on the release output one clock after acceptance. A dropped packet without that flag produces no output at all.
- R6: A non-dropped packet with the exception flag (bit 2) or the no-match flag (bit 1) goes to the special-handling output and is not enqueued. `exc_kind` is 1 when exception is set (exception wins over no-match) and 0 for no-match alone.
- R7: A packet that is not dropped never drives the release output, even with the final-copy flag set.
- R8: An output that is valid and not accepted keeps its valid and all of its data unchanged on the next cycle.
- R9: `in_ready` is low exactly while some loaded output is not being accepted this cycle. A stalled descriptor is taken when the output drains, and is not lost. With all outputs ready, descriptors are accepted on consecutive cycles.
- R10: After reset, all output valids are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_flags | input | 16 | Flag word (bit0 drop, bit1 no-match, bit2 exception, bit8 datagram, bit9 final copy, bit10 plugin) |
| in_link | input | 3 | Virtual link number |
| in_qid | input | 10 | Queue ID |
| in_ptr | input | 20 | Packet pointer |
| in_len | input | 11 | Total length |
| enq_valid | output | 1 | Enqueue request present |
| enq_ready | input | 1 | Enqueue request taken |
| enq_index | output | 12 | Flat queue index {set, offset} |
| enq_ptr | output | 20 | Packet pointer of the request |
| enq_len | output | 11 | Total length of the request |
| exc_valid | output | 1 | Special-handling packet present |
| exc_ready | input | 1 | Special-handling packet taken |
| exc_kind | output | 1 | 1 exception, 0 no-match |
| exc_ptr | output | 20 | Packet pointer |
| exc_len | output | 11 | Total length |
| rel_valid | output | 1 | Buffer release present |
| rel_ready | input | 1 | Buffer release taken |
| rel_ptr | output | 20 | Pointer whose payload may be freed |

## Verification
The bench sets drop together with exception and no-match. A wrong priority order would leak that packet to the enqueue or special-handling output. It sends final-copy packets on the enqueue and exception paths. A design that tied release to the final-copy flag alone would free a live buffer. Datagram and plugin packets use queue IDs with high bits set, so a missing modulo or a set number taken from the link would show up as a wrong index. A stalled output with a second descriptor waiting checks that the held data does not change. It also checks that the waiting descriptor is loaded on the very cycle the output drains, rather than being dropped or doubled.

// File: rtl/qsel_pkg.sv
package qsel_pkg;

    localparam int FLAG_W       = 16;
    localparam int DGRAM_QUEUES = 64;

    // flag bit positions, decoded from the classifier's flag word
    localparam int FB_DROP    = 0;
    localparam int FB_NOMATCH = 1;
    localparam int FB_EXCEPT  = 2;
    localparam int FB_DGRAM   = 8;
    localparam int FB_FINAL   = 9;
    localparam int FB_PLUGIN  = 10;

    typedef enum logic [1:0] {
        ROUTE_ENQ  = 2'd0,
        ROUTE_EXC  = 2'd1,
        ROUTE_DROP = 2'd2
    } route_e;

endpackage

// File: rtl/qsel_classify.sv
module qsel_classify
    import qsel_pkg::*;
#(
    parameter int NUM_LINKS = 8,
    parameter int QSET_SIZE = 256,
    parameter int QID_W     = 10,
    parameter int LINK_W    = 3,
    parameter int SET_W     = 4
) (
    input  logic [FLAG_W-1:0]                  flags,
    input  logic [LINK_W-1:0]                  link,
    input  logic [QID_W-1:0]                   qid,
    output route_e                             route,
    output logic                               exc_kind,
    output logic                               release_buf,
    output logic [SET_W+$clog2(QSET_SIZE)-1:0] index
);

    localparam int QSEL_W = $clog2(QSET_SIZE);
    localparam int DG_W   = $clog2(DGRAM_QUEUES);
    localparam logic [SET_W-1:0] PLUG_SET = SET_W'(NUM_LINKS);

    logic [SET_W-1:0]  set_num;
    logic [QSEL_W-1:0] q_off;

    always_comb begin
        // priority: drop, then exception/no-match, then enqueue
        if (flags[FB_DROP])
            route = ROUTE_DROP;
        else if (flags[FB_EXCEPT] || flags[FB_NOMATCH])
            route = ROUTE_EXC;
        else
            route = ROUTE_ENQ;

        exc_kind    = flags[FB_EXCEPT];
        release_buf = flags[FB_DROP] && flags[FB_FINAL];

        set_num = flags[FB_PLUGIN] ? PLUG_SET : SET_W'(link);
        q_off   = flags[FB_DGRAM] ? QSEL_W'(qid[DG_W-1:0]) : qid[QSEL_W-1:0];
        index   = {set_num, q_off};
    end

endmodule

// File: rtl/qsel_slot.sv
module qsel_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         can_load
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.vld = 1'b1;
            st_d.dat = load_data;
        end else if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;
    assign can_load  = !st_q.vld || out_ready;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_load_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> can_load);

endmodule

// File: rtl/qsel_front.sv
module qsel_front
    import qsel_pkg::*;
#(
    parameter int NUM_LINKS = 8,
    parameter int QSET_SIZE = 256,
    parameter int PTR_W     = 20,
    parameter int QID_W     = 10,
    parameter int LEN_W     = 11,
    localparam int LINK_W   = $clog2(NUM_LINKS),
    localparam int SET_W    = $clog2(NUM_LINKS + 1),
    localparam int IDX_W    = SET_W + $clog2(QSET_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic [LINK_W-1:0] in_link,
    input  logic [QID_W-1:0]  in_qid,
    input  logic [PTR_W-1:0]  in_ptr,
    input  logic [LEN_W-1:0]  in_len,
    output logic              enq_valid,
    input  logic              enq_ready,
    output logic [IDX_W-1:0]  enq_index,
    output logic [PTR_W-1:0]  enq_ptr,
    output logic [LEN_W-1:0]  enq_len,
    output logic              exc_valid,
    input  logic              exc_ready,
    output logic              exc_kind,
    output logic [PTR_W-1:0]  exc_ptr,
    output logic [LEN_W-1:0]  exc_len,
    output logic              rel_valid,
    input  logic              rel_ready,
    output logic [PTR_W-1:0]  rel_ptr
);

    localparam int ENQ_DW = IDX_W + PTR_W + LEN_W;
    localparam int EXC_DW = 1 + PTR_W + LEN_W;
    localparam logic [SET_W-1:0] PLUG_SET = SET_W'(NUM_LINKS);

    route_e           route;
    logic             cls_kind;
    logic             cls_release;
    logic [IDX_W-1:0] cls_index;

    logic accept;
    logic ld_enq, ld_exc, ld_rel;
    logic room_enq, room_exc, room_rel;
    logic [ENQ_DW-1:0] enq_data;
    logic [EXC_DW-1:0] exc_data;

    qsel_classify #(
        .NUM_LINKS (NUM_LINKS),
        .QSET_SIZE (QSET_SIZE),
        .QID_W     (QID_W),
        .LINK_W    (LINK_W),
        .SET_W     (SET_W)
    ) u_classify (
        .flags       (in_flags),
        .link        (in_link),
        .qid         (in_qid),
        .route       (route),
        .exc_kind    (cls_kind),
        .release_buf (cls_release),
        .index       (cls_index)
    );

    always_comb begin
        in_ready = room_enq && room_exc && room_rel;
        accept   = in_valid && in_ready;
        ld_enq   = accept && (route == ROUTE_ENQ);
        ld_exc   = accept && (route == ROUTE_EXC);
        ld_rel   = accept && (route == ROUTE_DROP) && cls_release;
    end

    qsel_slot #(.W(ENQ_DW)) u_enq_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_enq),
        .load_data ({cls_index, in_ptr, in_len}),
        .out_ready (enq_ready),
        .out_valid (enq_valid),
        .out_data  (enq_data),
        .can_load  (room_enq)
    );

    qsel_slot #(.W(EXC_DW)) u_exc_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_exc),
        .load_data ({cls_kind, in_ptr, in_len}),
        .out_ready (exc_ready),
        .out_valid (exc_valid),
        .out_data  (exc_data),
        .can_load  (room_exc)
    );

    qsel_slot #(.W(PTR_W)) u_rel_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_rel),
        .load_data (in_ptr),
        .out_ready (rel_ready),
        .out_valid (rel_valid),
        .out_data  (rel_ptr),
        .can_load  (room_rel)
    );

    assign {enq_index, enq_ptr, enq_len} = enq_data;
    assign {exc_kind, exc_ptr, exc_len}  = exc_data;

    assert_drop_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_flags[FB_DROP] |=> !enq_valid && !exc_valid);

    assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $onehot0({enq_valid, exc_valid, rel_valid}));

    assert_no_live_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !in_flags[FB_DROP] |=> !rel_valid);

    assert_set_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |-> enq_index[IDX_W-1 -: SET_W] <= PLUG_SET);

endmodule

// File: tb/qsel_front_bench.sv
`timescale 1ns/1ps
module qsel_front_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [15:0] in_flags;
    logic [2:0]  in_link;
    logic [9:0]  in_qid;
    logic [19:0] in_ptr;
    logic [10:0] in_len;
    logic        enq_valid, enq_ready;
    logic [11:0] enq_index;
    logic [19:0] enq_ptr;
    logic [10:0] enq_len;
    logic        exc_valid, exc_ready, exc_kind;
    logic [19:0] exc_ptr;
    logic [10:0] exc_len;
    logic        rel_valid, rel_ready;
    logic [19:0] rel_ptr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    qsel_front u_qsel_front (.*);

    function automatic logic [15:0] mkf(bit drop, bit nm, bit ex, bit dg, bit fc, bit pl);
        logic [15:0] f = '0;
        f[0] = drop; f[1] = nm; f[2] = ex; f[8] = dg; f[9] = fc; f[10] = pl;
        return f;
    endfunction

    function automatic logic [31:0] exp_idx(int link, int qid, bit dg, bit pl);
        int set = pl ? 8 : link;
        int off = dg ? (qid % 64) : (qid % 256);
        return 32'(set * 256 + off);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] f, int link, int qid, int ptr, int len);
        in_valid = 1'b1;
        in_flags = f;
        in_link  = 3'(link);
        in_qid   = 10'(qid);
        in_ptr   = 20'(ptr);
        in_len   = 11'(len);
    endtask

    // called at a negedge; returns at the next negedge with outputs loaded
    task automatic send(logic [15:0] f, int link, int qid, int ptr, int len);
        drive(f, link, qid, ptr, len);
        chk("R9 ready before send", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_none(string req);
        chk(req, {29'd0, enq_valid, exc_valid, rel_valid}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R10 enq_valid", 32'(enq_valid), 32'd0);
        chk("R10 exc_valid", 32'(exc_valid), 32'd0);
        chk("R10 rel_valid", 32'(rel_valid), 32'd0);
        chk("R10 in_ready",  32'(in_ready),  32'd1);
    endtask

    task automatic t_normal;
        send(mkf(0,0,0,0,0,0), 3, 'h2A5, 'hABCDE, 1500);
        chk("R1 valid", 32'(enq_valid), 32'd1);
        chk("R1 index", 32'(enq_index), exp_idx(3, 'h2A5, 0, 0));
        chk("R1 ptr",   32'(enq_ptr), 32'hABCDE);
        chk("R1 len",   32'(enq_len), 32'd1500);
        @(negedge clk);
        send(mkf(0,0,0,0,0,0), 7, 'h1FF, 'h00001, 64);
        chk("R1 index top link", 32'(enq_index), exp_idx(7, 'h1FF, 0, 0));
        @(negedge clk);
    endtask

    task automatic t_dgram;
        send(mkf(0,0,0,1,0,0), 2, 'h0F3, 'h12345, 40);
        chk("R2 dgram valid", 32'(enq_valid), 32'd1);
        chk("R2 dgram index", 32'(enq_index), exp_idx(2, 'h0F3, 1, 0));
        @(negedge clk);
    endtask

    task automatic t_plugin;
        send(mkf(0,0,0,0,0,1), 5, 'h03C, 'h55555, 100);
        chk("R3 plugin index", 32'(enq_index), exp_idx(5, 'h03C, 0, 1));
        @(negedge clk);
        send(mkf(0,0,0,1,0,1), 1, 'h0C5, 'h66666, 100);
        chk("R3 plugin dgram index", 32'(enq_index), exp_idx(1, 'h0C5, 1, 1));
        @(negedge clk);
    endtask

    task automatic t_drop;
        send(mkf(1,1,1,0,0,0), 4, 'h10, 'h77777, 200);
        check_none("R4 drop with exc/nm, no final copy R5");
        @(negedge clk);
        send(mkf(1,0,1,0,1,0), 4, 'h10, 'h88888, 200);
        chk("R5 release valid", 32'(rel_valid), 32'd1);
        chk("R5 release ptr",   32'(rel_ptr), 32'h88888);
        chk("R4 no enq/exc", {30'd0, enq_valid, exc_valid}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_exc;
        send(mkf(0,1,1,0,1,0), 6, 'h20, 'h99999, 300);
        chk("R6 exc valid", 32'(exc_valid), 32'd1);
        chk("R6 exc kind",  32'(exc_kind), 32'd1);
        chk("R6 exc ptr",   32'(exc_ptr), 32'h99999);
        chk("R6 no enq",    32'(enq_valid), 32'd0);
        chk("R7 no release on exc", 32'(rel_valid), 32'd0);
        @(negedge clk);
        send(mkf(0,1,0,0,0,0), 6, 'h20, 'h11111, 77);
        chk("R6 nomatch kind", 32'(exc_kind), 32'd0);
        chk("R6 nomatch len",  32'(exc_len), 32'd77);
        @(negedge clk);
        send(mkf(0,0,0,0,1,0), 0, 'h5, 'h22222, 60);
        chk("R7 enq with final copy", 32'(enq_valid), 32'd1);
        chk("R7 no release on enq",   32'(rel_valid), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_hold;
        enq_ready = 1'b0;
        send(mkf(0,0,0,0,0,0), 1, 'h10, 'hA0A0A, 90);
        drive(mkf(0,0,0,0,0,0), 4, 'h20, 'hB0B0B, 91);
        for (int i = 0; i < 3; i++) begin
            chk("R9 stalled ready",  32'(in_ready), 32'd0);
            chk("R8 held valid",     32'(enq_valid), 32'd1);
            chk("R8 held index",     32'(enq_index), exp_idx(1, 'h10, 0, 0));
            chk("R8 held ptr",       32'(enq_ptr), 32'hA0A0A);
            @(negedge clk);
        end
        enq_ready = 1'b1;
        #0.5;
        chk("R9 ready on drain", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 waiting packet loaded", 32'(enq_index), exp_idx(4, 'h20, 0, 0));
        chk("R9 waiting packet ptr",    32'(enq_ptr), 32'hB0B0B);
        @(negedge clk);
        chk("R9 drained", 32'(enq_valid), 32'd0);
    endtask

    task automatic t_b2b;
        drive(mkf(0,0,0,0,0,0), 0, 'h01, 'h00010, 10);
        @(negedge clk);
        chk("R9 b2b first", 32'(enq_index), exp_idx(0, 'h01, 0, 0));
        chk("R9 b2b ready", 32'(in_ready), 32'd1);
        drive(mkf(0,0,0,0,0,0), 6, 'h3FF, 'h00020, 20);
        @(negedge clk);
        chk("R9 b2b second", 32'(enq_index), exp_idx(6, 'h3FF, 0, 0));
        drive(mkf(0,0,1,0,0,0), 6, 'h3FF, 'h00030, 30);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 b2b third exc", {30'd0, enq_valid, exc_valid}, 32'd1);
        chk("R9 b2b third ptr", 32'(exc_ptr), 32'h00030);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_flags = '0; in_link = '0; in_qid = '0;
        in_ptr = '0; in_len = '0;
        enq_ready = 1'b1; exc_ready = 1'b1; rel_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_dgram();
        t_plugin();
        t_drop();
        t_exc();
        t_hold();
        t_b2b();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule